// File: doc/BRIEF.md
# Zero-Overhead Loop Controller

This block sits next to a program counter and removes the branch instruction from the end of a counted loop. When a loop instruction issues, the controller is given the address of the last instruction in the loop body and an iteration count. It saves the address that follows the loop instruction as the loop start. From then on it compares the current PC with the end address on every cycle. At the end address it either sends the PC back to the saved start or lets it fall through, depending on whether passes remain.

A second mode repeats a single instruction. The instruction after the loop-issuing instruction becomes both the start and the end of the loop. Interrupts are held off while that repeat runs. The iteration counter is 8 bits wide by default. A count of zero selects the full range of 256 passes rather than zero passes. Only one loop level is tracked. A new loop instruction replaces the current loop.

Top module: `zol_ctrl`

## Requirements
- R1: While rst_ni is low and after its release with no loop issued, loop_active_o and irq_inhibit_o are 0 and next_pc_o equals pc_i + 1.
- R2: With no loop active, next_pc_o equals pc_i + 1 (modulo 2^PC_W) for any pc_i.
- R3: In a cycle with loop_start_i high, next_pc_o is pc_i + 1. That value is saved as the loop start, and the loop is live from the following cycle.
- R4: While a loop is live and pc_i equals the end address with passes remaining, next_pc_o is the saved start.
- R5: While a loop is live and pc_i differs from the end address, next_pc_o is pc_i + 1.
- R6: A count N in 1..255 gives exactly N passes through the body: N-1 jumps back, then a fall-through to end + 1.
- R7: A count of 0 gives 256 passes through the body.
- R8: loop_active_o is already 0 in the cycle of the final fall-through. It stays 0 afterwards, including when pc_i later equals the old end address.
- R9: When rpt_i is high at loop issue, the end address is taken as pc_i + 1 and end_addr_i is ignored. The single instruction there runs count times.
- R10: irq_inhibit_o is high exactly while a repeat-mode loop shows loop_active_o high. It is never high for a block loop.
- R11: A loop_start_i while a loop is live discards the old loop and starts the new one with its own start, end and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loop_start_i | input | 1 | Loop instruction issues at pc_i this cycle |
| rpt_i | input | 1 | With loop_start_i: 1 = single-instruction repeat, 0 = block loop |
| end_addr_i | input | PC_W | Address of the last body instruction (block loop) |
| count_i | input | CNT_W | Iteration count, 0 means 2^CNT_W |
| pc_i | input | PC_W | Current program counter |
| next_pc_o | output | PC_W | Program counter for the next cycle |
| loop_active_o | output | 1 | A loop is live and this is not its final fall-through |
| irq_inhibit_o | output | 1 | Interrupts must be held off (repeat running) |

## Verification
Some properties are checked by assertions on every cycle. A loop-issue cycle always steps to pc_i + 1. An idle controller never redirects the PC, and any redirect occurs only with a loop live. The interrupt hold never appears without a live loop, and the flag cannot rise again without a new loop instruction. Three things can only be shown by the bench's scenarios, because each needs the whole sequence of a run: the exact number of passes for each count (including zero meaning 256), the cycle in which the flag drops, and the replacement of a live loop by a new one.

// File: rtl/zol_pkg.sv
package zol_pkg;
  typedef enum logic {
    KIND_BLOCK  = 1'b0,
    KIND_REPEAT = 1'b1
  } loop_kind_e;
endpackage

// File: rtl/zol_iter_cnt.sv
module zol_iter_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  localparam int unsigned REM_W = CNT_W + 1;
  localparam logic [REM_W-1:0] FULL = REM_W'(1) << CNT_W;
  localparam logic [REM_W-1:0] ONE  = REM_W'(1);

  logic [REM_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= ONE;
    end else if (load_i) begin
      // zero selects the full range
      rem_q <= (load_val_i == '0) ? FULL : {1'b0, load_val_i};
    end else if (dec_i) begin
      rem_q <= rem_q - ONE;
    end
  end

  assign last_o = (rem_q == ONE);
endmodule

// File: rtl/zol_bounds.sv
module zol_bounds #(
  parameter int unsigned PC_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            rpt_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] end_addr_i,
  output logic [PC_W-1:0] start_o,
  output logic            end_hit_o
);
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  logic [PC_W-1:0] start_q, end_q, pc_inc;

  assign pc_inc = pc_i + ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      end_q   <= '0;
    end else if (load_i) begin
      start_q <= pc_inc;
      end_q   <= rpt_i ? pc_inc : end_addr_i;
    end
  end

  assign start_o   = start_q;
  assign end_hit_o = (pc_i == end_q);
endmodule

// File: rtl/zol_ctrl.sv
module zol_ctrl
  import zol_pkg::*;
#(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             loop_start_i,
  input  logic             rpt_i,
  input  logic [PC_W-1:0]  end_addr_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             loop_active_o,
  output logic             irq_inhibit_o
);
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  logic            active_q;
  loop_kind_e      kind_q;
  logic [PC_W-1:0] start_addr;
  logic            end_hit, last_pass, jump_back, exit_now;

  zol_bounds #(.PC_W(PC_W)) u_bounds (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (loop_start_i),
    .rpt_i      (rpt_i),
    .pc_i       (pc_i),
    .end_addr_i (end_addr_i),
    .start_o    (start_addr),
    .end_hit_o  (end_hit)
  );

  zol_iter_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (loop_start_i),
    .load_val_i (count_i),
    .dec_i      (jump_back),
    .last_o     (last_pass)
  );

  assign jump_back = active_q & end_hit & ~last_pass & ~loop_start_i;
  assign exit_now  = active_q & end_hit & last_pass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      kind_q   <= KIND_BLOCK;
    end else if (loop_start_i) begin
      active_q <= 1'b1;
      kind_q   <= rpt_i ? KIND_REPEAT : KIND_BLOCK;
    end else if (exit_now) begin
      active_q <= 1'b0;
    end
  end

  assign next_pc_o     = jump_back ? start_addr : pc_i + ONE;
  assign loop_active_o = active_q & ~exit_now;
  assign irq_inhibit_o = loop_active_o & (kind_q == KIND_REPEAT);
endmodule

// File: rtl/zol_ctrl_chk.sv
module zol_ctrl_chk #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             loop_start_i,
  input logic             rpt_i,
  input logic [PC_W-1:0]  end_addr_i,
  input logic [CNT_W-1:0] count_i,
  input logic [PC_W-1:0]  pc_i,
  input logic [PC_W-1:0]  next_pc_o,
  input logic             loop_active_o,
  input logic             irq_inhibit_o
);
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  logic unused_ok;
  assign unused_ok = rpt_i ^ (^end_addr_i) ^ (^count_i);

  // R3
  issue_steps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_start_i |-> next_pc_o == pc_i + ONE);

  // R4
  redirect_needs_loop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (next_pc_o != pc_i + ONE) |-> loop_active_o);

  // R10
  inhibit_in_loop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_inhibit_o |-> loop_active_o);

  // R8
  stays_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loop_active_o && !loop_start_i) |=> !loop_active_o);
endmodule

bind zol_ctrl zol_ctrl_chk #(.PC_W(PC_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/zol_ctrl_test.sv
module zol_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loop_start = 1'b0;
  logic        rpt = 1'b0;
  logic [15:0] end_addr = '0;
  logic [7:0]  count = '0;
  logic [15:0] pc = '0;
  logic [15:0] next_pc;
  logic        active, inhibit;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  zol_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .loop_start_i(loop_start), .rpt_i(rpt),
    .end_addr_i(end_addr), .count_i(count), .pc_i(pc),
    .next_pc_o(next_pc), .loop_active_o(active), .irq_inhibit_o(inhibit)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at negedge, sample 1 time unit later.
  task automatic step(input logic [15:0] p, input logic st);
    @(negedge clk);
    pc = p;
    loop_start = st;
    #1;
  endtask

  // Issue a loop at p; body length len (1 in repeat mode); count c.
  task automatic run_loop(input logic [15:0] p, input int len, input int c,
                          input logic rp, input string req);
    int passes, body, jumps, act_cyc, inh_cyc;
    logic [15:0] exit_pc;
    passes  = (c == 0) ? 256 : c;
    exit_pc = 16'(p + len + 1);
    rpt = rp;
    count = 8'(c);
    end_addr = rp ? 16'(p + 40) : 16'(p + len); // R9: ignored in repeat
    step(p, 1'b1);
    check({"R3 ", req}, next_pc, 16'(p + 1));
    body = 0; jumps = 0; act_cyc = 0; inh_cyc = 0;
    for (int guard = 0; guard < 2000; guard++) begin
      logic [15:0] np;
      np = next_pc;
      step(np, 1'b0);
      if (pc == exit_pc) break;
      body++;
      if (active) act_cyc++;
      if (inhibit) inh_cyc++;
      if (next_pc != 16'(pc + 1)) begin
        jumps++;
        check({"R4 ", req}, next_pc, 16'(p + 1));
      end
    end
    check({"R6/R7 passes ", req}, body, passes * len);
    check({"R6 jumps ", req}, jumps, passes - 1);
    check({"R8 active cycles ", req}, act_cyc, passes * len - 1);
    check({"R10 inhibit cycles ", req}, inh_cyc, rp ? passes - 1 : 0);
    check({"R8 idle at exit ", req}, active, 0);
    step(16'(exit_pc - 1), 1'b0);
    check({"R8 old end ignored ", req}, next_pc, exit_pc);
  endtask

  initial begin
    int cnts[7] = '{1, 2, 3, 5, 17, 255, 0};
    pc = 16'd100;
    #1;
    check("R1 reset next", next_pc, 101);
    check("R1 reset active", active, 0);
    check("R1 reset inhibit", inhibit, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step(16'd300, 1'b0);
    check("R1 after release", next_pc, 301);
    check("R1 after release active", active, 0);

    // R2 idle sweep including wrap
    for (int k = 0; k < 32; k++) begin
      logic [15:0] p;
      p = 16'(k * 2053);
      step(p, 1'b0);
      check("R2 idle", next_pc, 16'(p + 1));
    end
    step(16'hFFFF, 1'b0);
    check("R2 wrap", next_pc, 0);

    // R5/R6/R7 block loops, R9/R10 repeat
    for (int m = 0; m < 2; m++)
      for (int len = 1; len <= 3; len++) begin
        if (m == 1 && len > 1) continue;
        foreach (cnts[i])
          run_loop(16'(1000 + 64 * len), len, cnts[i], logic'(m),
                   m ? "repeat" : "block");
      end

    // R11 restart while live
    rpt = 1'b0; count = 8'd5; end_addr = 16'd2002;
    step(16'd2000, 1'b1);
    for (int k = 0; k < 3; k++) begin
      logic [15:0] np;
      np = next_pc;
      step(np, 1'b0);
    end
    check("R11 live before restart", active, 1);
    run_loop(16'd3000, 2, 3, 1'b0, "R11 restart");
    step(16'd2002, 1'b0);
    check("R11 old loop gone", next_pc, 2003);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule